// File: doc/BRIEF.md
# Receive Buffer Credit Flow Controller

This block keeps the number of free receive buffers for one MAC receive channel and decides when the far end of the link must be slowed down. Software hands buffers back by writing a count to an add port. That count is summed into the credit register; it does not overwrite it. The receive DMA engine takes one credit each time it consumes a buffer descriptor. Both updates may arrive in the same clock, and the register then moves by their net amount.

When receive flow control is on and the credit count is at or below a programmable threshold, the block raises a throttle action. On a full-duplex link this action is a request to transmit pause frames. On a half-duplex link it is a request to force collisions. Each incoming frame start that meets a forced collision produces a collision pulse and advances a collision counter.

A separate transmit flow-control enable decides whether pause indications received from the link partner are obeyed. When they are obeyed, a hold output stops the local transmitter for the requested number of pause quanta. Each quantum lasts a configurable number of clock cycles.

Top module: `rbfc_top`

## Requirements
- R1: A DMA take with no software add in the same cycle lowers `free_count` by exactly one on the next clock edge, provided the count is not zero.
- R2: A software add with no DMA take in the same cycle raises `free_count` by `sw_add_cnt` on the next clock edge. The value is added, not loaded.
- R3: If a software add and a DMA take happen in the same cycle, `free_count` changes by `sw_add_cnt` minus one, and both updates take effect.
- R4: `free_count` saturates at 2^CNT_W-1 when credits are added. A take when the count plus any same-cycle add is zero leaves the count at zero and sets the sticky `underflow` flag, which stays high until reset.
- R5: The registered throttle action is active on the edge where receive flow control is enabled and the new count is at or below `cfg_thresh`. It drops on the first edge where the new count is above the threshold, or where receive flow control is off.
- R6: When the throttle action is active and `cfg_full_duplex`=1, `pause_req`=1 and `force_col`=0. With `cfg_full_duplex`=0, `force_col`=1 and `pause_req`=0. The two outputs are never high together.
- R7: If `force_col` is high and `rx_sof` is high in the same cycle, `col_pulse` goes high for the next cycle and `col_count` goes up by one. No pulse is produced at any other time.
- R8: If `cfg_tx_fc_en`=1 and `rx_pause_valid` carries a quanta value Q, `tx_hold` is high for exactly Q*P cycles, starting on the next edge. P is `cfg_prescale`, and a value of 0 counts as 1. Q=0 releases the hold. A new indication reloads the timer.
- R9: If `cfg_tx_fc_en`=0, a received pause indication has no effect and `tx_hold` stays low. Receive and transmit flow control can each be enabled on its own.
- R10: A synchronous active-high `rst` clears `free_count`, `underflow`, `col_count`, and all throttle, collision and hold outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_full_duplex | input | 1 | 1 = full duplex (pause action), 0 = half duplex (collision action) |
| cfg_rx_fc_en | input | 1 | Enables throttling of the link partner |
| cfg_tx_fc_en | input | 1 | Enables obeying received pause indications |
| cfg_thresh | input | CNT_W | Free-credit level at or below which throttling starts |
| cfg_prescale | input | PRESC_W | Clock cycles per pause quantum (0 treated as 1) |
| sw_add_valid | input | 1 | Software credit return strobe |
| sw_add_cnt | input | CNT_W | Number of credits returned |
| dma_take | input | 1 | DMA consumed one buffer descriptor |
| rx_sof | input | 1 | Start of an incoming frame on the line |
| rx_pause_valid | input | 1 | A valid pause indication was received |
| rx_pause_quanta | input | QUANTA_W | Pause length in quanta |
| free_count | output | CNT_W | Current free credit count |
| underflow | output | 1 | Sticky: a take found no credit |
| pause_req | output | 1 | Request transmission of pause frames |
| force_col | output | 1 | Request forced collisions |
| col_pulse | output | 1 | One-cycle pulse per forced collision |
| col_count | output | COLCNT_W | Forced collision counter |
| tx_hold | output | 1 | Hold the local transmitter |

## Verification
The hardest case to reach from the ports is a software add and a DMA take arriving in the same cycle. It is hardest at the edges: at full scale, where the add alone would overflow, and at an empty count, where the take alone would underflow. The stimulus walks the count to each edge with single adds and takes. It then fires the combined update there and checks that the net result is add minus one, and that the underflow flag stays clear. A reference model in the bench follows every cycle, so the threshold crossing in each direction and the switch of duplex mode while throttling are checked on the same edge where the design's registers update.

// File: rtl/rbfc_pkg.sv
package rbfc_pkg;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_PAUSE   = 2'd1,
        ACT_COLLIDE = 2'd2
    } thr_action_e;

    typedef struct packed {
        logic add;
        logic take;
    } credit_ev_t;

    function automatic thr_action_e pick_action(input logic rx_en,
                                                input logic full_dup,
                                                input logic at_or_below);
        thr_action_e a;
        if (!(rx_en && at_or_below))
            a = ACT_NONE;
        else if (full_dup)
            a = ACT_PAUSE;
        else
            a = ACT_COLLIDE;
        return a;
    endfunction

endpackage

// File: rtl/rbfc_credit_ctr.sv
module rbfc_credit_ctr
    import rbfc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  credit_ev_t       ev,
    input  logic [CNT_W-1:0] add_amt,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_nxt,
    output logic             underflow_q
);
    localparam int SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] MAX_CNT = SUM_W'((1 << CNT_W) - 1);

    logic [SUM_W-1:0] sum_w;
    logic [SUM_W-1:0] net_w;
    logic             empty_hit;

    always_comb begin
        sum_w     = {1'b0, count_q} + (ev.add ? {1'b0, add_amt} : '0);
        empty_hit = 1'b0;
        net_w     = sum_w;
        if (ev.take) begin
            if (sum_w == '0)
                empty_hit = 1'b1;
            else
                net_w = sum_w - 1'b1;
        end
        if (net_w > MAX_CNT)
            count_nxt = MAX_CNT[CNT_W-1:0];
        else
            count_nxt = net_w[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q     <= '0;
            underflow_q <= 1'b0;
        end else begin
            count_q <= count_nxt;
            if (empty_hit)
                underflow_q <= 1'b1;
        end
    end

    // R1: single take lowers the count by one
    assert_take_one_R1: assert property (@(posedge clk) disable iff (rst)
        (ev.take && !ev.add && count_q != '0) |=> count_q == CNT_W'($past(count_q) - 1'b1));

    // R2: add without overflow sums into the count
    assert_add_sum_R2: assert property (@(posedge clk) disable iff (rst)
        (ev.add && !ev.take && ({1'b0, count_q} + {1'b0, add_amt}) <= MAX_CNT)
        |=> count_q == CNT_W'($past(count_q) + $past(add_amt)));

    // R3: simultaneous add and take give add minus one
    assert_both_net_R3: assert property (@(posedge clk) disable iff (rst)
        (ev.add && ev.take && add_amt != '0 && ({1'b0, count_q} + {1'b0, add_amt}) <= MAX_CNT + 1'b1)
        |=> count_q == CNT_W'($past(count_q) + $past(add_amt) - 1'b1));

    // R4: underflow flag is sticky
    assert_underflow_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        underflow_q |=> underflow_q);

    // R4: take on empty sets the flag and keeps zero
    assert_empty_take_R4: assert property (@(posedge clk) disable iff (rst)
        (ev.take && count_q == '0 && (!ev.add || add_amt == '0)) |=> (underflow_q && count_q == '0));

endmodule

// File: rtl/rbfc_throttle.sv
module rbfc_throttle
    import rbfc_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int COLCNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_fc_en,
    input  logic                full_duplex,
    input  logic [CNT_W-1:0]    thresh,
    input  logic [CNT_W-1:0]    count_nxt,
    input  logic                rx_sof,
    output logic                pause_req,
    output logic                force_col,
    output logic                col_pulse,
    output logic [COLCNT_W-1:0] col_count
);
    thr_action_e act_nxt;
    thr_action_e act_q;

    always_comb begin
        act_nxt = pick_action(rx_fc_en, full_duplex, count_nxt <= thresh);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q     <= ACT_NONE;
            col_pulse <= 1'b0;
            col_count <= '0;
        end else begin
            act_q     <= act_nxt;
            col_pulse <= (act_q == ACT_COLLIDE) && rx_sof;
            if ((act_q == ACT_COLLIDE) && rx_sof)
                col_count <= col_count + 1'b1;
        end
    end

    assign pause_req = (act_q == ACT_PAUSE);
    assign force_col = (act_q == ACT_COLLIDE);

    // R6: the two throttle forms never coexist
    assert_one_form_R6: assert property (@(posedge clk) disable iff (rst)
        !(pause_req && force_col));

    // R7: a collision pulse needs a forced collision and a frame start
    assert_col_cause_R7: assert property (@(posedge clk) disable iff (rst)
        col_pulse |-> ($past(force_col) && $past(rx_sof)));

    // R7: the counter advances with each pulse
    assert_col_count_R7: assert property (@(posedge clk) disable iff (rst)
        (force_col && rx_sof) |=> col_count == COLCNT_W'($past(col_count) + 1'b1));

endmodule

// File: rtl/rbfc_pause_timer.sv
module rbfc_pause_timer #(
    parameter int QUANTA_W = 16,
    parameter int PRESC_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tx_fc_en,
    input  logic [PRESC_W-1:0]  prescale,
    input  logic                pause_valid,
    input  logic [QUANTA_W-1:0] pause_quanta,
    output logic                tx_hold
);
    logic [QUANTA_W-1:0] quanta_left;
    logic [PRESC_W-1:0]  pre_cnt;
    logic [PRESC_W-1:0]  pre_last;

    always_comb begin
        pre_last = (prescale == '0) ? '0 : prescale - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !tx_fc_en) begin
            quanta_left <= '0;
            pre_cnt     <= '0;
        end else if (pause_valid) begin
            quanta_left <= pause_quanta;
            pre_cnt     <= '0;
        end else if (quanta_left != '0) begin
            if (pre_cnt >= pre_last) begin
                pre_cnt     <= '0;
                quanta_left <= quanta_left - 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    assign tx_hold = (quanta_left != '0);

    // R8: an accepted non-zero pause starts a hold
    assert_hold_start_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_fc_en && pause_valid && pause_quanta != '0) |=> tx_hold);

    // R9: with transmit flow control off, no hold
    assert_hold_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        !tx_fc_en |=> !tx_hold);

endmodule

// File: rtl/rbfc_top.sv
module rbfc_top
    import rbfc_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int QUANTA_W = 16,
    parameter int PRESC_W  = 8,
    parameter int COLCNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_full_duplex,
    input  logic                cfg_rx_fc_en,
    input  logic                cfg_tx_fc_en,
    input  logic [CNT_W-1:0]    cfg_thresh,
    input  logic [PRESC_W-1:0]  cfg_prescale,
    input  logic                sw_add_valid,
    input  logic [CNT_W-1:0]    sw_add_cnt,
    input  logic                dma_take,
    input  logic                rx_sof,
    input  logic                rx_pause_valid,
    input  logic [QUANTA_W-1:0] rx_pause_quanta,
    output logic [CNT_W-1:0]    free_count,
    output logic                underflow,
    output logic                pause_req,
    output logic                force_col,
    output logic                col_pulse,
    output logic [COLCNT_W-1:0] col_count,
    output logic                tx_hold
);
    credit_ev_t       ev;
    logic [CNT_W-1:0] count_nxt;

    assign ev.add  = sw_add_valid;
    assign ev.take = dma_take;

    rbfc_credit_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .add_amt    (sw_add_cnt),
        .count_q    (free_count),
        .count_nxt  (count_nxt),
        .underflow_q(underflow)
    );

    rbfc_throttle #(.CNT_W(CNT_W), .COLCNT_W(COLCNT_W)) u_thr (
        .clk        (clk),
        .rst        (rst),
        .rx_fc_en   (cfg_rx_fc_en),
        .full_duplex(cfg_full_duplex),
        .thresh     (cfg_thresh),
        .count_nxt  (count_nxt),
        .rx_sof     (rx_sof),
        .pause_req  (pause_req),
        .force_col  (force_col),
        .col_pulse  (col_pulse),
        .col_count  (col_count)
    );

    rbfc_pause_timer #(.QUANTA_W(QUANTA_W), .PRESC_W(PRESC_W)) u_pt (
        .clk         (clk),
        .rst         (rst),
        .tx_fc_en    (cfg_tx_fc_en),
        .prescale    (cfg_prescale),
        .pause_valid (rx_pause_valid),
        .pause_quanta(rx_pause_quanta),
        .tx_hold     (tx_hold)
    );

    // R5: any throttle output implies rx enable and count at or below threshold
    assert_throttle_level_R5: assert property (@(posedge clk) disable iff (rst)
        (pause_req || force_col) |-> ($past(cfg_rx_fc_en) && free_count <= $past(cfg_thresh)));

    // R5: count above threshold with rx enabled releases throttling
    assert_throttle_release_R5: assert property (@(posedge clk) disable iff (rst)
        (free_count > $past(cfg_thresh)) |-> !(pause_req || force_col));

    // R10: reset clears state and outputs
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (free_count == '0 && !underflow && !pause_req && !force_col
                 && !col_pulse && col_count == '0 && !tx_hold));

endmodule

// File: tb/sim_rbfc_top.sv
`timescale 1ns/1ps
module sim_rbfc_top;
    localparam int CW = 8;
    localparam int QW = 16;
    localparam int PW = 8;
    localparam int KW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fd = 1'b1, rxen = 1'b1, txen = 1'b0;
    logic [CW-1:0] thr = 8'd2;
    logic [PW-1:0] presc = 8'd3;
    logic          addv = 1'b0;
    logic [CW-1:0] addn = '0;
    logic          take = 1'b0, sof = 1'b0, pv = 1'b0;
    logic [QW-1:0] pq = '0;

    logic [CW-1:0] free_count;
    logic          underflow, pause_req, force_col, col_pulse, tx_hold;
    logic [KW-1:0] col_count;

    always #4 clk = ~clk;

    rbfc_top u0 (
        .clk(clk), .rst(rst), .cfg_full_duplex(fd), .cfg_rx_fc_en(rxen),
        .cfg_tx_fc_en(txen), .cfg_thresh(thr), .cfg_prescale(presc),
        .sw_add_valid(addv), .sw_add_cnt(addn), .dma_take(take), .rx_sof(sof),
        .rx_pause_valid(pv), .rx_pause_quanta(pq), .free_count(free_count),
        .underflow(underflow), .pause_req(pause_req), .force_col(force_col),
        .col_pulse(col_pulse), .col_count(col_count), .tx_hold(tx_hold)
    );

    typedef struct {
        int    kind;
        int    exp;
        string req;
    } exp_t;
    exp_t sb[$];

    int checks = 0, errors = 0;
    int m_cnt = 0, m_unf = 0, m_pause = 0, m_force = 0, m_colp = 0, m_colc = 0, m_left = 0;
    string cur_req = "R10";

    function automatic int observe(input int kind);
        case (kind)
            0: return int'(free_count);
            1: return int'(underflow);
            2: return int'(pause_req);
            3: return int'(force_col);
            4: return int'(col_pulse);
            5: return int'(col_count);
            default: return int'(tx_hold);
        endcase
    endfunction

    function automatic string kname(input int kind);
        case (kind)
            0: return "free_count";
            1: return "underflow";
            2: return "pause_req";
            3: return "force_col";
            4: return "col_pulse";
            5: return "col_count";
            default: return "tx_hold";
        endcase
    endfunction

    // monitor: pops expected items and compares away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t it;
                int   act;
                it  = sb.pop_front();
                act = observe(it.kind);
                checks++;
                if (act != it.exp) begin
                    errors++;
                    $display("FAIL %s %s actual=%0d expected=%0d at %0t",
                             it.req, kname(it.kind), act, it.exp, $time);
                end
            end
        end
    end

    task automatic push_all();
        sb.push_back('{0, m_cnt, cur_req});
        sb.push_back('{1, m_unf, cur_req});
        sb.push_back('{2, m_pause, cur_req});
        sb.push_back('{3, m_force, cur_req});
        sb.push_back('{4, m_colp, cur_req});
        sb.push_back('{5, m_colc, cur_req});
        sb.push_back('{6, (m_left != 0) ? 1 : 0, cur_req});
    endtask

    // driver: applies one cycle of stimulus, advances the reference, queues expectations
    task automatic cyc(input bit a_v, input int a_n, input bit t, input bit s,
                       input bit p_v, input int p_q);
        int sum, pe, old_force, th;
        addv = a_v; addn = CW'(a_n); take = t; sof = s; pv = p_v; pq = QW'(p_q);
        @(posedge clk);
        #1;
        old_force = m_force;
        sum = m_cnt + (a_v ? a_n : 0);
        if (t) begin
            if (sum == 0) m_unf = 1;
            else sum = sum - 1;
        end
        if (sum > 255) sum = 255;
        m_cnt = sum;
        th = (rxen && m_cnt <= int'(thr)) ? 1 : 0;
        m_pause = th && fd;
        m_force = th && !fd;
        m_colp = old_force && s;
        if (m_colp) m_colc++;
        pe = (presc == 0) ? 1 : int'(presc);
        if (!txen) m_left = 0;
        else if (p_v) m_left = p_q * pe;
        else if (m_left > 0) m_left--;
        addv = 0; take = 0; sof = 0; pv = 0;
        push_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        cur_req = "R10";
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        m_cnt = 0; m_unf = 0; m_pause = 0; m_force = 0; m_colp = 0; m_colc = 0; m_left = 0;
        push_all();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        cur_req = "R5";  cyc(0, 0, 0, 0, 0, 0);          // count 0 <= thr: pause
        cur_req = "R2";  cyc(1, 5, 0, 0, 0, 0);          // 5, throttle released
        cur_req = "R1";  cyc(0, 0, 1, 0, 0, 0);          // 4
        cur_req = "R1";  cyc(0, 0, 1, 0, 0, 0);          // 3
        cur_req = "R5";  cyc(0, 0, 1, 0, 0, 0);          // 2: throttle on
        cur_req = "R5";  cyc(1, 1, 0, 0, 0, 0);          // 3: throttle off
        cur_req = "R3";  cyc(1, 4, 1, 0, 0, 0);          // 6
        cur_req = "R3";  cyc(1, 1, 1, 0, 0, 0);          // 6 unchanged
        cur_req = "R4";  cyc(1, 250, 0, 0, 0, 0);        // saturate 255
        cur_req = "R3";  cyc(1, 1, 1, 0, 0, 0);          // 255 at full scale
        cur_req = "R3";  cyc(1, 0, 1, 0, 0, 0);          // 254
        do_reset();
        cur_req = "R3";  cyc(1, 1, 1, 0, 0, 0);          // empty + combined: 0, no underflow
        cur_req = "R4";  cyc(0, 0, 1, 0, 0, 0);          // underflow set
        cur_req = "R4";  cyc(1, 3, 0, 0, 0, 0);          // flag sticky
        cur_req = "R6";  fd = 1'b0; cyc(0, 0, 1, 0, 0, 0);  // half duplex, 2: collide
        cur_req = "R7";  cyc(0, 0, 0, 1, 0, 0);
        cur_req = "R7";  cyc(0, 0, 0, 1, 0, 0);
        cur_req = "R7";  cyc(1, 9, 0, 1, 0, 0);          // sof seen while forcing
        cur_req = "R7";  cyc(0, 0, 0, 1, 0, 0);          // no longer forcing: no pulse
        cur_req = "R6";  fd = 1'b1; cyc(0, 0, 1, 0, 0, 0);
        cur_req = "R6";  thr = 8'd20; cyc(0, 0, 0, 0, 0, 0);
        cur_req = "R5";  rxen = 1'b0; cyc(0, 0, 0, 1, 0, 0);
        cur_req = "R9";  cyc(0, 0, 0, 0, 1, 2);          // tx flow control off: ignored
        cur_req = "R9";  idle(2);
        cur_req = "R8";  txen = 1'b1; cyc(0, 0, 0, 0, 1, 2);
        cur_req = "R8";  idle(8);
        cur_req = "R8";  cyc(0, 0, 0, 0, 1, 3);
        cur_req = "R8";  idle(3);
        cur_req = "R8";  cyc(0, 0, 0, 0, 1, 1);          // reload shorter
        cur_req = "R8";  idle(4);
        cur_req = "R8";  presc = 8'd0; cyc(0, 0, 0, 0, 1, 2);
        cur_req = "R8";  idle(3);
        cur_req = "R8";  cyc(0, 0, 0, 0, 1, 4);
        cur_req = "R8";  cyc(0, 0, 0, 0, 1, 0);          // zero quanta releases
        cur_req = "R9";  cyc(0, 0, 0, 0, 1, 5);
        cur_req = "R9";  txen = 1'b0; cyc(0, 0, 0, 0, 0, 0);
        cur_req = "R9";  rxen = 1'b1; thr = 8'd2; cyc(0, 0, 0, 0, 1, 5);
        do_reset();
        idle(1);
        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule